// File: doc/BRIEF.md
# Value-Aware Taint Propagation Slice

This block is a small datapath slice in which every data bit carries a one-bit taint label. Three operand vectors, a shared select and a tracked synchronous clear enter the slice. It computes four results: the bitwise AND of two operands, their bitwise OR, a 2:1 selection between them, and a composed function `(a & b) | c`. Each result is registered together with a label that states whether any tainted input could have changed that result bit.

Two label rules are available, chosen by the `precise` input. In value-aware mode, the label logic looks at the data values as well as the labels. An untainted controlling value therefore masks taint: a clean 0 into an AND, a clean 1 into an OR, or a clean select. In the conservative mode, a result label is the OR of every label in its input cone. Running the same traffic in both modes shows how much precision the value-aware rule gains.

The clear input is itself a tracked signal with its own label. It loads zero into the result registers. It is built from the same shadow cells as the rest of the slice, so a clean clear erases labels only in value-aware mode. In conservative mode, labels never shrink.

Top module: `glift_slice`

## Requirements
- R1: With `precise` = 0, each registered result label equals the OR of the labels feeding it. AND and OR depend on `clr_t`, `a_t` and `b_t`. The selection also depends on `sel_t`. The composed result depends on `clr_t`, `a_t`, `b_t` and `c_t`.
- R2: With `precise` = 1, the AND label is `(a & b_t) | (b & a_t) | (a_t & b_t)`. A clean 0 on either operand clears the label.
- R3: With `precise` = 1, the OR label is `(~a & b_t) | (~b & a_t) | (a_t & b_t)`. A clean 1 on either operand clears the label.
- R4: The selection returns `b` when `sel` = 1 and `a` when `sel` = 0. With `precise` = 1 and a clean select, the result takes the label of the chosen operand. A tainted select sets the label unless both operands are clean and equal.
- R5: With `precise` = 1, the label of the composed result `(a & b) | c` is set exactly when flipping some tainted input among a, b and c can change that result bit.
- R6: Every result and its label are sampled on the same rising edge. Both appear one cycle after the inputs.
- R7: `clr` = 1 with `clr_t` = 0 loads 0 into all results. In value-aware mode it also clears every label. In conservative mode the labels become the OR of the data labels, so they cannot shrink.
- R8: With a tainted clear in value-aware mode, a result label is set exactly when either clear value or a tainted data flip could change the registered bit.
- R9: Every data bit has its own label, and bit positions do not influence each other's labels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| precise | input | 1 | 1 = value-aware labels, 0 = conservative OR of labels |
| clr | input | 1 | Synchronous clear of the result registers, active high |
| clr_t | input | 1 | Taint label of `clr` |
| a | input | W | Operand a |
| a_t | input | W | Labels of operand a |
| b | input | W | Operand b |
| b_t | input | W | Labels of operand b |
| c | input | W | Operand c (composed function only) |
| c_t | input | W | Labels of operand c |
| sel | input | 1 | Selection control, 1 picks b |
| sel_t | input | 1 | Taint label of `sel` |
| y_and | output | W | Registered a & b |
| y_and_t | output | W | Labels of y_and |
| y_or | output | W | Registered a \| b |
| y_or_t | output | W | Labels of y_or |
| y_mux | output | W | Registered selection |
| y_mux_t | output | W | Labels of y_mux |
| y_cmp | output | W | Registered (a & b) \| c |
| y_cmp_t | output | W | Labels of y_cmp |

## Verification
The assertions assume that `clr` is held high on the first clock edge, so the result registers hold defined values before any property is enabled. They also assume that every input is stable for the whole cycle before each rising edge. The stimulus meets both assumptions: it drives all inputs on the falling edge, and it opens with a clean clear in value-aware mode. The sweep then covers every combination of values and labels on a, b, c, the select and the clear in both modes. Each label is compared with the result of flipping the tainted inputs.

// File: rtl/taint_pkg.sv
package taint_pkg;
  typedef enum logic {
    TRK_CONSERVATIVE = 1'b0,
    TRK_PRECISE      = 1'b1
  } track_mode_e;
endpackage

// File: rtl/taint_and.sv
module taint_and #(
  parameter int W = 8
) (
  input  logic         prec,
  input  logic [W-1:0] a,
  input  logic [W-1:0] at,
  input  logic [W-1:0] b,
  input  logic [W-1:0] bt,
  output logic [W-1:0] y,
  output logic [W-1:0] yt
);
  always_comb begin
    y = a & b;
    if (prec) yt = (a & bt) | (b & at) | (at & bt);
    else      yt = at | bt;
  end
endmodule

// File: rtl/taint_or.sv
module taint_or #(
  parameter int W = 8
) (
  input  logic         prec,
  input  logic [W-1:0] a,
  input  logic [W-1:0] at,
  input  logic [W-1:0] b,
  input  logic [W-1:0] bt,
  output logic [W-1:0] y,
  output logic [W-1:0] yt
);
  always_comb begin
    y = a | b;
    if (prec) yt = (~a & bt) | (~b & at) | (at & bt);
    else      yt = at | bt;
  end
endmodule

// File: rtl/taint_mux.sv
module taint_mux #(
  parameter int W = 8
) (
  input  logic         prec,
  input  logic         s,
  input  logic         st,
  input  logic [W-1:0] a,
  input  logic [W-1:0] at,
  input  logic [W-1:0] b,
  input  logic [W-1:0] bt,
  output logic [W-1:0] y,
  output logic [W-1:0] yt
);
  logic [W-1:0] s_v, st_v;
  always_comb begin
    s_v  = {W{s}};
    st_v = {W{st}};
    y    = s ? b : a;
    if (prec) yt = (~s_v & at) | (s_v & bt) | (st_v & ((a ^ b) | at | bt));
    else      yt = st_v | at | bt;
  end
endmodule

// File: rtl/taint_regs.sv
module taint_regs #(
  parameter int W   = 8,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    prec,
  input  logic                    clr,
  input  logic                    clr_t,
  input  logic [NCH-1:0][W-1:0]   d,
  input  logic [NCH-1:0][W-1:0]   dt,
  output logic [NCH-1:0][W-1:0]   q,
  output logic [NCH-1:0][W-1:0]   qt
);
  logic [W-1:0] keep_v, keep_t;
  logic [NCH-1:0][W-1:0] nx, nxt;

  assign keep_v = {W{~clr}};
  assign keep_t = {W{clr_t}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    taint_and #(.W(W)) u_gate (
      .prec(prec), .a(keep_v), .at(keep_t),
      .b(d[ch]), .bt(dt[ch]), .y(nx[ch]), .yt(nxt[ch])
    );
    always_ff @(posedge clk) begin
      q[ch]  <= nx[ch];
      qt[ch] <= nxt[ch];
    end
  end
endmodule

// File: rtl/glift_slice.sv
module glift_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         precise,
  input  logic         clr,
  input  logic         clr_t,
  input  logic [W-1:0] a,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] b,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] c,
  input  logic [W-1:0] c_t,
  input  logic         sel,
  input  logic         sel_t,
  output logic [W-1:0] y_and,
  output logic [W-1:0] y_and_t,
  output logic [W-1:0] y_or,
  output logic [W-1:0] y_or_t,
  output logic [W-1:0] y_mux,
  output logic [W-1:0] y_mux_t,
  output logic [W-1:0] y_cmp,
  output logic [W-1:0] y_cmp_t
);
  import taint_pkg::*;
  localparam int NCH = 4;

  track_mode_e mode;
  logic        prec;
  logic [W-1:0] and_v, and_t, or_v, or_t, mux_v, mux_t, cmp_v, cmp_t;
  logic [NCH-1:0][W-1:0] d, dt, q, qt;

  assign mode = track_mode_e'(precise);
  assign prec = (mode == TRK_PRECISE);

  taint_and #(.W(W)) u_and (.prec(prec), .a(a), .at(a_t), .b(b), .bt(b_t),
                            .y(and_v), .yt(and_t));
  taint_or  #(.W(W)) u_or  (.prec(prec), .a(a), .at(a_t), .b(b), .bt(b_t),
                            .y(or_v), .yt(or_t));
  taint_mux #(.W(W)) u_mux (.prec(prec), .s(sel), .st(sel_t), .a(a), .at(a_t),
                            .b(b), .bt(b_t), .y(mux_v), .yt(mux_t));
  // composition: AND cell output feeds a second OR cell with operand c
  taint_or  #(.W(W)) u_cmp (.prec(prec), .a(and_v), .at(and_t), .b(c), .bt(c_t),
                            .y(cmp_v), .yt(cmp_t));

  assign d  = {cmp_v, mux_v, or_v, and_v};
  assign dt = {cmp_t, mux_t, or_t, and_t};

  taint_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk(clk), .prec(prec), .clr(clr), .clr_t(clr_t),
    .d(d), .dt(dt), .q(q), .qt(qt)
  );

  assign y_and   = q[0];
  assign y_and_t = qt[0];
  assign y_or    = q[1];
  assign y_or_t  = qt[1];
  assign y_mux   = q[2];
  assign y_mux_t = qt[2];
  assign y_cmp   = q[3];
  assign y_cmp_t = qt[3];

  // R1: conservative labels are the OR of the cone labels
  p_cons_and_r1: assert property (@(posedge clk) disable iff (clr)
    (!precise) |=> (y_and_t == $past(a_t | b_t | {W{clr_t}})));
  // R2: clean zero operand masks AND taint
  p_and_mask_r2: assert property (@(posedge clk) disable iff (clr)
    (precise && !clr_t) |=> ((y_and_t & $past((~a & ~a_t) | (~b & ~b_t))) == '0));
  // R3: clean one operand masks OR taint
  p_or_mask_r3: assert property (@(posedge clk) disable iff (clr)
    (precise && !clr_t) |=> ((y_or_t & $past((a & ~a_t) | (b & ~b_t))) == '0));
  // R4: clean select passes the chosen operand label
  p_mux_pass_r4: assert property (@(posedge clk) disable iff (clr)
    (precise && !sel_t && !clr_t) |=> (y_mux_t == $past(sel ? b_t : a_t)));
  // R6: data captured one cycle later
  p_capture_r6: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (y_or == $past(a | b)));
  // R7: clean clear in precise mode zeroes data and labels
  p_clear_r7: assert property (@(posedge clk) disable iff (clr)
    $past(clr & ~clr_t & precise) |-> (y_cmp == '0 && y_cmp_t == '0 && y_mux_t == '0));
endmodule

// File: tb/glift_slice_test.sv
module glift_slice_test;
  localparam int W = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic precise, clr, clr_t, sel, sel_t;
  logic [W-1:0] a, a_t, b, b_t, c, c_t;
  logic [W-1:0] y_and, y_and_t, y_or, y_or_t, y_mux, y_mux_t, y_cmp, y_cmp_t;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  glift_slice #(.W(W)) uut (
    .clk(clk), .precise(precise), .clr(clr), .clr_t(clr_t),
    .a(a), .a_t(a_t), .b(b), .b_t(b_t), .c(c), .c_t(c_t),
    .sel(sel), .sel_t(sel_t),
    .y_and(y_and), .y_and_t(y_and_t), .y_or(y_or), .y_or_t(y_or_t),
    .y_mux(y_mux), .y_mux_t(y_mux_t), .y_cmp(y_cmp), .y_cmp_t(y_cmp_t)
  );

  // input vector index: [0]=a [1]=b [2]=c [3]=sel [4]=clr
  function automatic bit fval(int o, logic [4:0] v);
    bit r;
    case (o)
      0: r = v[0] & v[1];
      1: r = v[0] | v[1];
      2: r = v[3] ? v[1] : v[0];
      default: r = (v[0] & v[1]) | v[2];
    endcase
    return r & ~v[4];
  endfunction

  // exact label: does flipping tainted inputs change the output?
  function automatic bit flip_lbl(int o, logic [4:0] v, logic [4:0] l);
    bit r = 1'b0;
    for (int k = 0; k < 32; k++) begin
      logic [4:0] kk = 5'(k);
      if (((kk ^ v) & ~l) == 5'b0 && fval(o, kk) != fval(o, v)) r = 1'b1;
    end
    return r;
  endfunction

  function automatic bit cons_lbl(int o, logic [4:0] l);
    logic [4:0] cone;
    case (o)
      0, 1: cone = 5'b10011;
      2:    cone = 5'b11011;
      default: cone = 5'b10111;
    endcase
    return |(l & cone);
  endfunction

  function automatic string tag(int o, bit m, logic [4:0] v, logic [4:0] l, int bitn);
    if (bitn == 1) return "R9";
    if (!m) return "R1";
    if (v[4]) return l[4] ? "R8" : "R7";
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string rq, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic drive(bit m, logic [4:0] v, logic [4:0] l);
    logic [4:0] v1, l1;
    v1 = v ^ 5'b00111;
    l1 = {l[4:3], l[1:0], l[2]};
    precise = m;
    a = {v1[0], v[0]}; a_t = {l1[0], l[0]};
    b = {v1[1], v[1]}; b_t = {l1[1], l[1]};
    c = {v1[2], v[2]}; c_t = {l1[2], l[2]};
    sel = v[3]; sel_t = l[3];
    clr = v[4]; clr_t = l[4];
  endtask

  task automatic check_all(bit m, logic [4:0] v, logic [4:0] l);
    logic [4:0] vv, ll;
    logic [W-1:0] yv, yl;
    for (int bn = 0; bn < W; bn++) begin
      vv = (bn == 1) ? (v ^ 5'b00111) : v;
      ll = (bn == 1) ? {l[4:3], l[1:0], l[2]} : l;
      for (int o = 0; o < 4; o++) begin
        case (o)
          0: begin yv = y_and; yl = y_and_t; end
          1: begin yv = y_or;  yl = y_or_t;  end
          2: begin yv = y_mux; yl = y_mux_t; end
          default: begin yv = y_cmp; yl = y_cmp_t; end
        endcase
        chk("R6", yv[bn], fval(o, vv), $sformatf("value out%0d bit%0d v=%b", o, bn, vv));
        chk(tag(o, m, vv, ll, bn), yl[bn],
            m ? flip_lbl(o, vv, ll) : cons_lbl(o, ll),
            $sformatf("label out%0d bit%0d m=%0d v=%b l=%b", o, bn, m, vv, ll));
      end
    end
  endtask

  initial begin
    drive(1'b1, 5'b11111, 5'b00000);  // clean clear, precise, data all ones
    @(negedge clk);
    // R7: reset state is zero with clear labels
    chk("R7", |{y_and, y_or, y_mux, y_cmp}, 1'b0, "reset data");
    chk("R7", |{y_and_t, y_or_t, y_mux_t, y_cmp_t}, 1'b0, "reset labels");
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 32; v++)
        for (int l = 0; l < 32; l++) begin
          drive(m[0], 5'(v), 5'(l));
          @(negedge clk);
          check_all(m[0], 5'(v), 5'(l));
        end
    // R7: conservative clean clear keeps a tainted data label
    drive(1'b0, 5'b10011, 5'b00001);
    @(negedge clk);
    chk("R7", y_and_t[0], 1'b1, "conservative clear keeps label");
    chk("R7", y_and[0], 1'b0, "conservative clear zeroes data");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule